// File: doc/BRIEF.md
# Delayed-LMS Weight Update Unit

This block keeps the coefficient set of a delayed least-mean-squares adaptive FIR filter and adjusts every coefficient each time an error value arrives. Input samples come in on one stream and go into a sample line. Error values come in on a second stream. Each error is paired with the sample vector as it stood a fixed number of samples earlier. This extra delay is the adaptation delay of the error path.

The step size is a power of two, so the error is scaled by an arithmetic right shift and no multiplier is needed for it. The scaled error and its small multiples (zero, one, two and three times) are formed once and shared by every tap. Each tap multiplies by its delayed sample one 2-bit digit at a time. The partial products pass through a two-level shift-add tree with a register between the levels. The result is added to the old coefficient, and the sum is clamped to the coefficient range.

The coefficients are driven out at once. They are also driven out a second time through a separate delay, for a filtering datapath that works on older coefficients to shorten its own timing paths.

Top module: `dlms_weight_update`

## Requirements
- R1: A synchronous active-high `rst` clears every coefficient and every delayed-coefficient stage to zero. `in_ready` and `err_ready` are low while `rst` is high.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. Sample line entry 0 holds the most recently accepted sample. Tap i (i = 0..N-1) uses entry ADAPT_DELAY+i as that entry stood just before the edge where the error is accepted.
- R3: The scaled error is `err_data` (signed) arithmetically shifted right by STEP_LOG = STEP_INT_BITS + log2(N). Negative errors therefore round toward minus infinity.
- R4: The increment for tap i is floor(scaled_error × x_i / 2^(L−1)), where x_i is the signed L-bit delayed sample. It is computed exactly from the 2-bit digits of x_i. The top digit is taken as signed.
- R5: An error accepted on rising edge k changes the coefficient outputs right after edge k+1, with no earlier effect.
- R6: Errors may be accepted on consecutive edges. Each one applies its own increment, in order, to the coefficient left by the one before.
- R7: Each coefficient update saturates to [−2^(W−1), 2^(W−1)−1] instead of wrapping.
- R8: While no error is in flight, the coefficients hold their values, even while samples keep arriving.
- R9: `w_late` equals `w_now` as it was WT_DELAY cycles earlier. With the default of WT_DELAY = 1, this is one cycle.
- R10: Outside reset, `in_ready` and `err_ready` stay high on every cycle. The unit never applies back-pressure, so a producer may hold `*_valid` high for as long as it likes and each high cycle is one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready (high outside reset) |
| in_x | input | L | Input sample, signed, L−1 fraction bits |
| err_valid | input | 1 | Error stream valid |
| err_ready | output | 1 | Error stream ready (high outside reset) |
| err_data | input | W | Delayed error value, signed |
| w_now | output | N·W | Current coefficients, tap i in bits [i·W +: W] |
| w_late | output | N·W | Coefficients delayed by WT_DELAY cycles, same layout |

## Verification
An error accepted at rising edge k is due on `w_now` after edge k+1. The same value is due on `w_late` one edge later. The bench samples every output on the falling edge, once per cycle. It advances its own model of the sample line, of the pending increment and of the coefficients by exactly one edge between two samples. The pending increment is applied one edge after the error, so its two-cycle latency shows up as an exact-cycle comparison. The delayed copy is compared against the model value held back one cycle.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

  localparam int DIGIT_W    = 2;
  localparam int PAIR_SHIFT = 2 * DIGIT_W;

  typedef enum logic [2:0] {
    PICK_ZERO,
    PICK_P1,
    PICK_P2,
    PICK_P3,
    PICK_M1,
    PICK_M2
  } pick_e;

  // Map a radix-4 digit to a multiple of the scaled error.
  // Lower digits are unsigned 0..3; the top digit is signed -2..1.
  function automatic pick_e digit_pick(input logic [1:0] bits, input logic is_top);
    pick_e r;
    unique case (bits)
      2'b00:   r = PICK_ZERO;
      2'b01:   r = PICK_P1;
      2'b10:   r = is_top ? PICK_M2 : PICK_P2;
      default: r = is_top ? PICK_M1 : PICK_P3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dlms_sample_line.sv
module dlms_sample_line #(
  parameter int N           = 8,
  parameter int L           = 8,
  parameter int ADAPT_DELAY = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic [L-1:0]   x_i,
  output logic [N*L-1:0] xd_o
);
  localparam int DEPTH = N + ADAPT_DELAY;

  logic [L-1:0] ln [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) ln[k] <= '0;
    end else if (fire) begin
      ln[0] <= x_i;
      for (int k = 1; k < DEPTH; k++) ln[k] <= ln[k-1];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_tap
    assign xd_o[i*L +: L] = ln[ADAPT_DELAY + i];
  end

  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    fire |=> ln[0] == $past(x_i));

  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(ln[DEPTH-1]));

endmodule

// File: rtl/dlms_err_multiples.sv
module dlms_err_multiples #(
  parameter int W        = 16,
  parameter int STEP_LOG = 4
) (
  input  logic [W-1:0]        err_i,
  output logic [4*(W+2)-1:0]  mult_o
);
  localparam int MW = W + 2;

  logic signed [W-1:0]  me;
  logic signed [MW-1:0] m1, m2, m3;

  always_comb begin
    me = $signed(err_i) >>> STEP_LOG;
    m1 = {{2{me[W-1]}}, me};
    m2 = m1 <<< 1;
    m3 = m1 + m2;
  end

  assign mult_o = {m3, m2, m1, {MW{1'b0}}};

endmodule

// File: rtl/dlms_tap_mac.sv
module dlms_tap_mac
  import dlms_pkg::*;
#(
  parameter int W = 16,
  parameter int L = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                s1_valid,
  input  logic [L-1:0]        x_i,
  input  logic [4*(W+2)-1:0]  mult_i,
  output logic [W-1:0]        w_o
);
  localparam int MW = W + 2;
  localparam int PW = W + L;
  localparam int ND = L / DIGIT_W;
  localparam int NP = ND / 2;
  localparam logic signed [PW-1:0] SMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [PW-1:0] pp  [ND];
  logic signed [PW-1:0] pr  [NP];
  logic signed [PW-1:0] prod, inc, sum, sat;
  logic        [W-1:0]  w_q;

  // Partial products: one shared multiple per digit, no local multiplier.
  always_comb begin
    for (int d = 0; d < ND; d++) begin
      logic signed [MW-1:0] m;
      pick_e sel;
      sel = digit_pick(x_i[d*DIGIT_W +: DIGIT_W], d == ND - 1);
      unique case (sel)
        PICK_P1: m = mult_i[1*MW +: MW];
        PICK_P2: m = mult_i[2*MW +: MW];
        PICK_P3: m = mult_i[3*MW +: MW];
        PICK_M1: m = -mult_i[1*MW +: MW];
        PICK_M2: m = -mult_i[2*MW +: MW];
        default: m = '0;
      endcase
      pp[d] = {{(PW-MW){m[MW-1]}}, m};
    end
  end

  // Shift-add stage 1, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) pr[p] <= '0;
    end else if (fire) begin
      for (int p = 0; p < NP; p++) pr[p] <= pp[2*p] + (pp[2*p+1] <<< DIGIT_W);
    end
  end

  // Shift-add stage 2, scaling, saturating accumulate.
  always_comb begin
    prod = '0;
    for (int p = 0; p < NP; p++) prod = prod + (pr[p] <<< (PAIR_SHIFT * p));
    inc = prod >>> (L - 1);
    sum = {{(PW-W){w_q[W-1]}}, w_q} + inc;
    if (sum > SMAX)      sat = SMAX;
    else if (sum < SMIN) sat = SMIN;
    else                 sat = sum;
  end

  always_ff @(posedge clk) begin
    if (rst)           w_q <= '0;
    else if (s1_valid) w_q <= sat[W-1:0];
  end

  assign w_o = w_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> w_q == '0);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> $stable(w_q));

  a_r7_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !inc[PW-1]) |=> $signed(w_q) >= $signed($past(w_q)));

  a_r7_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && inc[PW-1]) |=> $signed(w_q) <= $signed($past(w_q)));

endmodule

// File: rtl/dlms_weight_update.sv
module dlms_weight_update #(
  parameter int N             = 8,
  parameter int L             = 8,
  parameter int W             = 16,
  parameter int ADAPT_DELAY   = 2,
  parameter int WT_DELAY      = 1,
  parameter int STEP_INT_BITS = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [L-1:0]   in_x,
  input  logic           err_valid,
  output logic           err_ready,
  input  logic [W-1:0]   err_data,
  output logic [N*W-1:0] w_now,
  output logic [N*W-1:0] w_late
);
  localparam int STEP_LOG = STEP_INT_BITS + $clog2(N);
  localparam int MW       = W + 2;

  logic              in_fire, err_fire, s1_valid;
  logic [N*L-1:0]    xd;
  logic [4*MW-1:0]   mult;

  assign in_ready  = ~rst;
  assign err_ready = ~rst;
  assign in_fire   = in_valid & in_ready;
  assign err_fire  = err_valid & err_ready;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= err_fire;
  end

  dlms_sample_line #(.N(N), .L(L), .ADAPT_DELAY(ADAPT_DELAY)) u_line (
    .clk(clk), .rst(rst), .fire(in_fire), .x_i(in_x), .xd_o(xd)
  );

  dlms_err_multiples #(.W(W), .STEP_LOG(STEP_LOG)) u_mult (
    .err_i(err_data), .mult_o(mult)
  );

  for (genvar i = 0; i < N; i++) begin : g_tap
    dlms_tap_mac #(.W(W), .L(L)) u_mac (
      .clk(clk), .rst(rst), .fire(err_fire), .s1_valid(s1_valid),
      .x_i(xd[i*L +: L]), .mult_i(mult), .w_o(w_now[i*W +: W])
    );
  end

  if (WT_DELAY == 0) begin : g_nodly
    assign w_late = w_now;
  end else begin : g_dly
    logic [N*W-1:0] pipe [WT_DELAY];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < WT_DELAY; k++) pipe[k] <= '0;
      end else begin
        pipe[0] <= w_now;
        for (int k = 1; k < WT_DELAY; k++) pipe[k] <= pipe[k-1];
      end
    end
    assign w_late = pipe[WT_DELAY-1];
  end

  a_r5_no_early_change: assert property (@(posedge clk) disable iff (rst)
    (!err_fire && !s1_valid) |=> ##1 $stable(w_now));

endmodule

// File: tb/dlms_weight_update_bench.sv
module dlms_weight_update_bench;
  localparam int N = 8, L = 8, W = 16, AD = 2, SL = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, err_valid = 1'b0;
  logic [L-1:0] in_x = '0;
  logic [W-1:0] err_data = '0;
  logic in_ready, err_ready;
  logic [N*W-1:0] w_now, w_late;

  always #10 clk = ~clk;

  dlms_weight_update u_dlms_weight_update (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x),
    .err_valid(err_valid), .err_ready(err_ready), .err_data(err_data),
    .w_now(w_now), .w_late(w_late)
  );

  int checks = 0, errors = 0;
  int line_m [N+AD];
  int w_m [N];
  int w_lm [N];
  int pend [N];
  bit pend_v = 0;

  function automatic int step_inc(int e, int x);
    longint me, prod;
    me = longint'(e) >>> SL;
    prod = me * longint'(x);
    return int'(prod >>> (L - 1));
  endfunction

  function automatic int clamp(int s);
    if (s > (1 << (W-1)) - 1) return (1 << (W-1)) - 1;
    if (s < -(1 << (W-1))) return -(1 << (W-1));
    return s;
  endfunction

  function automatic logic [N*W-1:0] pack(input int a [N]);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i][W-1:0];
    return r;
  endfunction

  task automatic check(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: compare state from the last edge, drive, advance model by one edge.
  task automatic cyc(string tag, bit iv, int ix, bit ev, int ed);
    @(negedge clk);
    check({tag, " w_now"}, w_now, pack(w_m));
    check("R9 w_late", w_late, pack(w_lm));
    checks++;
    if (in_ready !== 1'b1 || err_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 actual=%b%b expected=11", in_ready, err_ready);
    end
    in_valid = iv; in_x = ix[L-1:0]; err_valid = ev; err_data = ed[W-1:0];
    for (int i = 0; i < N; i++) w_lm[i] = w_m[i];
    if (pend_v) for (int i = 0; i < N; i++) w_m[i] = clamp(w_m[i] + pend[i]);
    pend_v = ev;
    if (ev) for (int i = 0; i < N; i++) pend[i] = step_inc(ed, line_m[AD+i]);
    if (iv) begin
      for (int k = N+AD-1; k > 0; k--) line_m[k] = line_m[k-1];
      line_m[0] = ix;
    end
  endtask

  function automatic int rs(int bits);
    return int'($urandom % (1 << bits)) - (1 << (bits-1));
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R5 actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    foreach (line_m[k]) line_m[k] = 0;
    foreach (w_m[i]) begin w_m[i] = 0; w_lm[i] = 0; pend[i] = 0; end
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset w_now", w_now, '0);
    check("R1 reset w_late", w_late, '0);
    checks++;
    if (in_ready !== 1'b0 || err_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 ready actual=%b%b expected=00", in_ready, err_ready);
    end
    rst = 1'b0;
    // R8: samples only, coefficients hold
    for (int c = 0; c < 12; c++) cyc("R8 hold", 1, rs(L), 0, 0);
    // R2/R5: impulse walk, single isolated errors to see alignment and latency
    for (int c = 0; c < N + AD + 2; c++) begin
      cyc("R2 align", 1, (c == 0) ? 64 : 0, 0, 0);
      cyc("R5 latency", 0, 0, 1, 16000);
      cyc("R5 latency", 0, 0, 0, 0);
    end
    // R3: small negative errors, arithmetic shift rounding
    for (int c = 0; c < 10; c++) cyc("R3 small", 1, rs(L), 1, -(c + 1));
    // R4: random mix
    for (int c = 0; c < 400; c++)
      cyc("R4 random", ($urandom % 10) < 7, rs(L), ($urandom % 2) == 1, rs(W));
    // R6: back-to-back errors
    for (int c = 0; c < 24; c++) cyc("R6 b2b", 1, rs(L), 1, rs(W));
    // R7: saturate up, then down, including the most negative sample
    for (int c = 0; c < N + AD; c++) cyc("R7 fill", 1, 127, 0, 0);
    for (int c = 0; c < 60; c++) cyc("R7 sat high", 0, 0, 1, 32767);
    for (int c = 0; c < 80; c++) cyc("R7 sat low", 0, 0, 1, -32768);
    for (int c = 0; c < N + AD; c++) cyc("R7 fill", 1, -128, 0, 0);
    for (int c = 0; c < 80; c++) cyc("R7 sat neg x", 0, 0, 1, -32768);
    for (int c = 0; c < 6; c++) cyc("R8 drain", 1, rs(L), 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule